// File: doc/BRIEF.md
# Background Register Spill Engine

This block takes over the machine state bookkeeping when an interrupt arrives. It first writes a restore-status word at the head of a save area in memory. It then moves the core onto a separate interrupt register bank and places the save area address in a fixed register of that bank. While the handler runs on the interrupt bank, the block copies the interrupted program's main bank into the save area in the background, one word per granted memory cycle. When the copy ends, it rewrites the status word to mark the save as complete.

The register groups that the interrupted program was allowed to use are captured from the group enable inputs at entry. Only those groups are copied out and later reloaded. On return from interrupt, two paths are possible. If the copy has not finished, the block abandons it and simply switches back to the main bank, which the handler never touched. If the copy has finished, the block first refills the enabled registers from memory and then switches back, so that any edits made to the save area take effect.

The status output can be queried at any time. A request to switch to another user context is refused until the save is complete.

Top module: `spill_engine`

## Requirements
- R1: After reset the main bank is active, the status output is 0, and no memory request, acknowledge, grant or deny is asserted.
- R2: An interrupt taken while idle writes the status word first, at the save base address. Its value is group mask in bits [7:4] and code 2'b01 in bits [1:0], zero-extended. In the cycle after that write is granted, the interrupt bank becomes active, the acknowledge pulses for exactly one cycle, and interrupt-bank register 0 holds the save base.
- R3: Register i of the main bank is written to address base+1+i. Writes go in ascending register order, one per cycle in which the grant is high, and the engine stalls while the grant is low.
- R4: Register i belongs to group i/(NUM_REGS/NUM_GRP). Registers of groups whose enable bit was low at entry are neither written nor reloaded, and their save slots keep their previous contents. The status output carries the captured mask in bits [7:4].
- R5: After the last register, the status word at the base is rewritten with code 2'b10 (save complete), and the status output shows the same byte. Code 2'b11 never appears, and no memory write follows completion.
- R6: A return while the save is complete reloads every enabled register from its slot, with memory reads only, and then switches back to the main bank. The main registers take the memory contents as they are at return time.
- R7: A return while the save is in progress switches back to the main bank in the next cycle. It issues no memory read, leaves the main registers unchanged, and clears the status output to 0.
- R8: A context switch request is answered one cycle later. It is granted only if the save is complete; otherwise it is denied.
- R9: An interrupt arriving while an interrupt is being serviced is held pending and is taken only after the return has completed.
- R10: The register port reads and writes the active bank only. Handler writes to the interrupt bank never change the main bank.
- R11: A return command while the main bank is active has no effect on the bank, the status or the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request pulse |
| irq_ack_o | output | 1 | One-cycle pulse when the interrupt bank becomes active |
| rti_i | input | 1 | Return-from-interrupt command pulse |
| grp_en_i | input | NUM_GRP | Register group enables of the running program |
| save_base_i | input | ADDR_W | Save area base address, captured at entry |
| ctx_sw_req_i | input | 1 | Request to switch to another user context |
| ctx_sw_grant_o | output | 1 | Context switch accepted |
| ctx_sw_deny_o | output | 1 | Context switch refused |
| status_o | output | 8 | Current restore-status byte |
| bank_sel_o | output | 1 | 1 when the interrupt bank is active |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_gnt_i | input | 1 | Memory access accepted this cycle |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the grant cycle |
| rf_we_i | input | 1 | Register port write enable |
| rf_addr_i | input | clog2(NUM_REGS) | Register port index |
| rf_wdata_i | input | DATA_W | Register port write data |
| rf_rdata_o | output | DATA_W | Register port read data from the active bank |

## Verification
The hardest case to reach is a return that lands while the background copy is still in flight. With a steady grant, the copy finishes within a few cycles of the bank switch. The bench therefore waits for the switch and then removes the memory grant, which freezes the engine mid-save. In that state it asks for a context switch, rewrites the whole save area, and then issues the return. The main registers must come back untouched, and no read may appear. The reload path is told apart from a plain bank swap in a similar way: every enabled slot is edited between completion and return, and the bench checks that the edits show up in the main bank for each of the sixteen group masks.

// File: rtl/spill_pkg.sv
package spill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_SPILL, ST_FIN, ST_SAVED, ST_RELOAD
  } spill_state_e;

  localparam logic [1:0] RS_BUSY = 2'b01;
  localparam logic [1:0] RS_DONE = 2'b10;

  function automatic logic [7:0] rs_byte(input logic [3:0] mask, input logic [1:0] code);
    return {mask, 2'b00, code};
  endfunction
endpackage

// File: rtl/spill_bank_rf.sv
module spill_bank_rf #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))      regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/spill_ctrl.sv
module spill_ctrl import spill_pkg::*; #(
  parameter int NUM_REGS = 8,
  parameter int NUM_GRP  = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_i,
  input  logic               rti_i,
  input  logic               ctx_sw_req_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic [ADDR_W-1:0]  save_base_i,
  input  logic               mem_gnt_i,
  input  logic [DATA_W-1:0]  reg_rdata_i,
  output logic               bank_sel_o,
  output logic               irq_ack_o,
  output logic               ctx_sw_grant_o,
  output logic               ctx_sw_deny_o,
  output logic [7:0]         status_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               reload_we_o,
  output logic               ptr_we_o,
  output logic [ADDR_W-1:0]  base_o
);
  localparam int RPG   = NUM_REGS / NUM_GRP;
  localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  spill_state_e       state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [NUM_GRP-1:0] mask_q;
  logic [ADDR_W-1:0]  base_q;
  logic [7:0]         stat_q;
  logic               bank_q, ack_q, pend_q, grant_q, deny_q;

  logic [GRP_W-1:0]   grp_sel;
  logic               cur_en, last, step;
  logic [3:0]         mask_pad;
  logic [ADDR_W-1:0]  slot_addr;

  assign grp_sel   = GRP_W'(int'(idx_q) / RPG);
  assign cur_en    = mask_q[grp_sel];
  assign last      = (idx_q == IDX_W'(NUM_REGS - 1));
  assign mask_pad  = 4'(mask_q);
  assign slot_addr = base_q + ADDR_W'(idx_q) + ADDR_W'(1);
  // a disabled register costs one cycle but no memory slot
  assign step      = !cur_en || mem_gnt_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    reload_we_o = 1'b0;
    ptr_we_o    = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = DATA_W'(rs_byte(mask_pad, RS_BUSY));
        ptr_we_o    = mem_gnt_i;
      end
      ST_SPILL: if (!rti_i && cur_en) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_addr;
        mem_wdata_o = reg_rdata_i;
      end
      ST_FIN: if (!rti_i) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = DATA_W'(rs_byte(mask_pad, RS_DONE));
      end
      ST_RELOAD: if (cur_en) begin
        mem_req_o   = 1'b1;
        mem_addr_o  = slot_addr;
        reload_we_o = mem_gnt_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      stat_q  <= '0;
      bank_q  <= 1'b0;
      ack_q   <= 1'b0;
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      ack_q   <= 1'b0;
      grant_q <= ctx_sw_req_i && (state_q == ST_SAVED);
      deny_q  <= ctx_sw_req_i && (state_q != ST_SAVED);
      if (irq_i && state_q != ST_IDLE) pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (irq_i || pend_q) begin
          mask_q  <= grp_en_i;
          base_q  <= save_base_i;
          pend_q  <= 1'b0;
          state_q <= ST_HDR;
        end
        ST_HDR: if (mem_gnt_i) begin
          bank_q  <= 1'b1;
          ack_q   <= 1'b1;
          stat_q  <= rs_byte(mask_pad, RS_BUSY);
          idx_q   <= '0;
          state_q <= ST_SPILL;
        end
        ST_SPILL: begin
          if (rti_i) begin
            bank_q  <= 1'b0;
            stat_q  <= '0;
            state_q <= ST_IDLE;
          end else if (step) begin
            if (last) state_q <= ST_FIN;
            else      idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_FIN: begin
          if (rti_i) begin
            bank_q  <= 1'b0;
            stat_q  <= '0;
            state_q <= ST_IDLE;
          end else if (mem_gnt_i) begin
            stat_q  <= rs_byte(mask_pad, RS_DONE);
            state_q <= ST_SAVED;
          end
        end
        ST_SAVED: if (rti_i) begin
          idx_q   <= '0;
          state_q <= ST_RELOAD;
        end
        ST_RELOAD: if (step) begin
          if (last) begin
            bank_q  <= 1'b0;
            stat_q  <= '0;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bank_sel_o     = bank_q;
  assign irq_ack_o      = ack_q;
  assign ctx_sw_grant_o = grant_q;
  assign ctx_sw_deny_o  = deny_q;
  assign status_o       = stat_q;
  assign idx_o          = idx_q;
  assign base_o         = base_q;
endmodule

// File: rtl/spill_engine.sv
module spill_engine import spill_pkg::*; #(
  parameter int NUM_REGS = 8,
  parameter int NUM_GRP  = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        irq_i,
  output logic                        irq_ack_o,
  input  logic                        rti_i,
  input  logic [NUM_GRP-1:0]          grp_en_i,
  input  logic [ADDR_W-1:0]           save_base_i,
  input  logic                        ctx_sw_req_i,
  output logic                        ctx_sw_grant_o,
  output logic                        ctx_sw_deny_o,
  output logic [7:0]                  status_o,
  output logic                        bank_sel_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic                        mem_gnt_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  input  logic                        rf_we_i,
  input  logic [$clog2(NUM_REGS)-1:0] rf_addr_i,
  input  logic [DATA_W-1:0]           rf_wdata_i,
  output logic [DATA_W-1:0]           rf_rdata_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0]  idx;
  logic              reload_we, ptr_we, bank_sel;
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] main_rd, irq_rd;

  logic              main_we, irq_we;
  logic [IDX_W-1:0]  main_waddr, main_raddr, irq_waddr;
  logic [DATA_W-1:0] main_wdata, irq_wdata;

  spill_ctrl #(
    .NUM_REGS(NUM_REGS), .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .irq_i, .rti_i, .ctx_sw_req_i, .grp_en_i, .save_base_i, .mem_gnt_i,
    .reg_rdata_i   (main_rd),
    .bank_sel_o    (bank_sel),
    .irq_ack_o, .ctx_sw_grant_o, .ctx_sw_deny_o, .status_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .idx_o         (idx),
    .reload_we_o   (reload_we),
    .ptr_we_o      (ptr_we),
    .base_o        (base)
  );

  // main bank: reload has priority; its read port serves the spill while the handler runs
  assign main_we    = reload_we || (rf_we_i && !bank_sel);
  assign main_waddr = reload_we ? idx : rf_addr_i;
  assign main_wdata = reload_we ? mem_rdata_i : rf_wdata_i;
  assign main_raddr = bank_sel ? idx : rf_addr_i;

  // interrupt bank: register 0 receives the save area pointer at entry
  assign irq_we    = ptr_we || (rf_we_i && bank_sel);
  assign irq_waddr = ptr_we ? '0 : rf_addr_i;
  assign irq_wdata = ptr_we ? DATA_W'(base) : rf_wdata_i;

  spill_bank_rf #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_main_bank (
    .clk_i, .rst_ni,
    .we_i(main_we), .waddr_i(main_waddr), .wdata_i(main_wdata),
    .raddr_i(main_raddr), .rdata_o(main_rd)
  );

  spill_bank_rf #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_irq_bank (
    .clk_i, .rst_ni,
    .we_i(irq_we), .waddr_i(irq_waddr), .wdata_i(irq_wdata),
    .raddr_i(rf_addr_i), .rdata_o(irq_rd)
  );

  assign bank_sel_o = bank_sel;
  assign rf_rdata_o = bank_sel ? irq_rd : main_rd;
endmodule

// File: rtl/spill_engine_chk.sv
module spill_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bank_sel_o,
  input logic       irq_ack_o,
  input logic       ctx_sw_grant_o,
  input logic [7:0] status_o,
  input logic       mem_req_o,
  input logic       mem_we_o
);
  assert_ack_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (bank_sel_o && status_o[1:0] == 2'b01));

  assert_ack_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);

  assert_code_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1:0] != 2'b11);

  assert_no_write_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1:0] == 2'b10) |-> !(mem_req_o && mem_we_o));

  assert_read_only_saved_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (status_o[1:0] == 2'b10));

  assert_clear_on_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bank_sel_o) |-> (status_o == 8'h00));

  assert_grant_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_sw_grant_o |-> ($past(status_o[1:0]) == 2'b10));
endmodule

bind spill_engine spill_engine_chk u_chk (.*);

// File: tb/spill_engine_test.sv
`timescale 1ns/1ps
module spill_engine_test;
  localparam int N = 8, G = 4, W = 16, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq = 0, rti = 0, ctx_req = 0, rf_we = 0;
  logic [G-1:0] grp_en = '0;
  logic [AW-1:0] base = '0;
  logic [2:0] rf_addr = '0;
  logic [W-1:0] rf_wdata = '0;
  logic irq_ack, grant, deny, bank_sel, mem_req, mem_we, gnt = 1'b1;
  logic [7:0] status;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_wdata, mem_rdata, rf_rdata;
  int gnt_mode = 0;

  logic [W-1:0] mem [256];
  logic poke_en = 0;
  logic [AW-1:0] poke_addr = '0;
  logic [W-1:0] poke_data = '0;

  int ack_cnt = 0, rd_cnt = 0, sp_cnt = 0, order_err = 0, hdr_cnt = 0;
  logic [AW-1:0] hdr_addr = '0, last_addr = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spill_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .irq_ack_o(irq_ack), .rti_i(rti),
    .grp_en_i(grp_en), .save_base_i(base), .ctx_sw_req_i(ctx_req),
    .ctx_sw_grant_o(grant), .ctx_sw_deny_o(deny), .status_o(status), .bank_sel_o(bank_sel),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(gnt), .mem_rdata_i(mem_rdata),
    .rf_we_i(rf_we), .rf_addr_i(rf_addr), .rf_wdata_i(rf_wdata), .rf_rdata_o(rf_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  always @(negedge clk)
    case (gnt_mode)
      0: gnt <= 1'b1;
      1: gnt <= ~gnt;
      default: gnt <= 1'b0;
    endcase

  // memory model and monitors
  always @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    if (irq_ack) ack_cnt <= ack_cnt + 1;
    if (mem_req && gnt && !mem_we) rd_cnt <= rd_cnt + 1;
    if (mem_req && gnt && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (status == 8'h00) begin
        hdr_addr  <= mem_addr;
        last_addr <= mem_addr;
        hdr_cnt   <= hdr_cnt + 1;
      end else if (mem_addr != hdr_addr) begin
        if (mem_addr <= last_addr) order_err <= order_err + 1;
        last_addr <= mem_addr;
        sp_cnt    <= sp_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); poke_en = 1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic rf_wr(input int a, input logic [W-1:0] d);
    @(negedge clk); rf_we = 1; rf_addr = 3'(a); rf_wdata = d;
    @(negedge clk); rf_we = 0;
  endtask

  task automatic rf_rd(input int a, output logic [W-1:0] d);
    @(negedge clk); rf_addr = 3'(a); #1; d = rf_rdata;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1; @(negedge clk); irq = 0;
  endtask

  task automatic pulse_rti();
    @(negedge clk); rti = 1; @(negedge clk); rti = 0;
  endtask

  task automatic pulse_ctx();
    @(negedge clk); ctx_req = 1; @(negedge clk); ctx_req = 0;
  endtask

  task automatic wait_code(input logic [1:0] c, input string tag);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (status[1:0] == c) return;
    end
    chk({tag, " timeout"}, status[1:0], c);
  endtask

  task automatic wait_bank(input logic v, input string tag);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (bank_sel == v) return;
    end
    chk({tag, " bank timeout"}, bank_sel, v);
  endtask

  function automatic logic [W-1:0] val(input int m, input int i);
    return {4'(m), 4'(i), 8'h3C};
  endfunction

  task automatic run(input int m, input int mode);
    logic [AW-1:0] b;
    logic [W-1:0] d;
    int pop, a0, s0, r0;
    b = AW'(16 + m * 12);
    pop = $countones(4'(m));
    for (int i = 0; i <= N; i++) poke(b + AW'(i), 16'hDEAD);
    for (int i = 0; i < N; i++) rf_wr(i, val(m, i));
    gnt_mode = mode; grp_en = 4'(m); base = b;
    a0 = ack_cnt; s0 = sp_cnt; r0 = rd_cnt;
    pulse_irq();
    wait_code(2'b10, "R5 completion");
    chk("R2 one ack", ack_cnt - a0, 1);
    chk("R2 header first at base", hdr_addr, b);
    chk("R5 status word in memory", mem[b], {8'h00, 4'(m), 4'h2});
    chk("R4 status mask", status, {4'(m), 4'h2});
    chk("R3 ascending order", order_err, 0);
    chk("R3 spill count", sp_cnt - s0, 2 * pop);
    for (int i = 0; i < N; i++)
      chk($sformatf("R3/R4 slot %0d mask %0h", i, m), mem[b + AW'(i + 1)],
          m[i / 2] ? val(m, i) : 16'hDEAD);
    rf_rd(0, d);
    chk("R2 pointer in interrupt bank", d, {8'h00, b});
    rf_wr(3, 16'hBEEF);
    for (int i = 0; i < N; i++)
      if (m[i / 2]) poke(b + AW'(i + 1), val(m, i) ^ 16'h0F0F);
    pulse_ctx();
    chk("R8 grant after save", {grant, deny}, 2'b10);
    gnt_mode = mode;
    pulse_rti();
    wait_bank(1'b0, "R6");
    chk("R6 status cleared", status, 8'h00);
    chk("R6 reload reads", rd_cnt - r0, 2 * pop);
    for (int i = 0; i < N; i++) begin
      rf_rd(i, d);
      chk($sformatf("R6/R10 main reg %0d mask %0h", i, m), d,
          m[i / 2] ? (val(m, i) ^ 16'h0F0F) : val(m, i));
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset outputs", {bank_sel, status, mem_req, irq_ack, grant, deny}, 13'h0);
    rst_n = 1;
    @(negedge clk);

    // R11: return with main bank active is ignored
    begin
      logic [W-1:0] d;
      int r0, h0;
      rf_wr(5, 16'h1234);
      r0 = rd_cnt; h0 = hdr_cnt;
      pulse_rti();
      repeat (3) @(negedge clk);
      chk("R11 bank stays main", bank_sel, 1'b0);
      chk("R11 status stays 0", status, 8'h00);
      chk("R11 no memory traffic", (rd_cnt - r0) + (hdr_cnt - h0), 0);
      rf_rd(5, d);
      chk("R11 register kept", d, 16'h1234);
    end

    // near-exhaustive sweep: every mask under two grant patterns
    for (int mode = 0; mode < 2; mode++)
      for (int m = 0; m < 16; m++) run(m, mode);

    // R7/R8: return during an in-progress save
    begin
      logic [W-1:0] d;
      int r0;
      for (int i = 0; i < N; i++) rf_wr(i, val(15, i) ^ 16'h1111);
      gnt_mode = 0; grp_en = 4'hF; base = 8'd220;
      pulse_irq();
      wait_bank(1'b1, "R7 entry");
      gnt_mode = 2;
      repeat (2) @(negedge clk);
      chk("R7 save in progress", status, 8'hF1);
      pulse_ctx();
      chk("R8 deny before save", {grant, deny}, 2'b01);
      for (int i = 1; i <= N; i++) poke(8'd220 + AW'(i), 16'h7777);
      r0 = rd_cnt;
      pulse_rti();
      chk("R7 bank back next cycle", bank_sel, 1'b0);
      chk("R7 status cleared", status, 8'h00);
      repeat (2) @(negedge clk);
      chk("R7 no reload reads", rd_cnt - r0, 0);
      for (int i = 0; i < N; i++) begin
        rf_rd(i, d);
        chk($sformatf("R7 main reg %0d intact", i), d, val(15, i) ^ 16'h1111);
      end
      gnt_mode = 0;
    end

    // R9: nested interrupt held until return
    begin
      int a0;
      grp_en = 4'h3; base = 8'd180;
      a0 = ack_cnt;
      pulse_irq();
      wait_code(2'b10, "R9 first save");
      pulse_irq();
      repeat (4) @(negedge clk);
      chk("R9 held while serviced", ack_cnt - a0, 1);
      chk("R9 still in handler", bank_sel, 1'b1);
      pulse_rti();
      for (int k = 0; k < 100 && ack_cnt - a0 < 2; k++) @(negedge clk);
      chk("R9 pending taken after return", ack_cnt - a0, 2);
      wait_code(2'b10, "R9 second save");
      pulse_rti();
      wait_bank(1'b0, "R9 exit");
      chk("R9 clean exit", status, 8'h00);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule